// File: doc/BRIEF.md
# Timed-Access Write Guard

This unit keeps a small set of critical control registers, such as watchdog controls and the power-fail/reset flag, safe from stray software stores. It watches one write port (address, data, strobe) together with a machine-cycle tick. The protected registers are not inside this unit. It only decides when they may be written. It tells them through a single `permit` output, which they qualify their own write enables with.

Software first stores the byte AAh and then the byte 55h to a dedicated key register, close together in time. A valid pair opens a short permission window measured in machine cycles. The window closes on the first store to any protected address, or when its machine-cycle budget runs out, whichever comes first.

The key register reads as zero. The key value, the second key, the key register address, the list of protected addresses and both time limits are parameters. The default machine cycle is one tick every four clocks, supplied on `mc_tick`.

Top module: `timed_access_guard`

## Requirements
- R1: After reset `permit` is 0 and the detector is idle, so a lone 55h store to the key register (address C7h by default) leaves `permit` at 0.
- R2: A store of AAh to the key register, followed by a store of 55h to the key register while the detector is armed, raises `permit` on the clock edge after the 55h store.
- R3: The detector stays armed only while fewer than ARM_MC (3) `mc_tick` pulses have occurred after the AAh store. A 55h store made after 3 or 4 such ticks leaves `permit` at 0. A 55h store made after 2 ticks opens the window.
- R4: A key-register store of any value other than AAh or 55h while armed returns the detector to idle. A repeated AAh store re-arms it with a full tick budget.
- R5: Once opened, `permit` stays 1 until the WIN_MC-th (3rd) `mc_tick` after the opening store, and is 0 from the following clock. A tick in the same cycle as the opening store is not counted.
- R6: A store to a protected address (D8h or D9h by default) while `permit` is 1 is the permitted write, and `permit` is 0 on the next clock. A protected store while `permit` is 0 has no effect.
- R7: Stores to unrelated addresses and reads of any address change neither the armed state nor the window.
- R8: A read of the key register raises `rd_sel` combinationally and returns `rd_data` = 0. A read of another address leaves `rd_sel` at 0.
- R9: A 55h store while the detector is idle never opens the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW (8) | Write address |
| wr_data | input | DW (8) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW (8) | Read address |
| permit | output | 1 | Protected-register write permission |
| rd_sel | output | 1 | Key register selected by current read |
| rd_data | output | DW (8) | Key register read value (always zero) |

## Verification
The bench goes after the arming boundary: a 55h store after exactly two, three and four ticks. A design that counts ticks one off either opens on a late sequence or refuses a timely one. It also checks that a tick landing on the AAh or 55h store cycle is not counted, since a design that counts it shortens each budget by one. A wrong-value second store followed by 55h must not open the window, which catches a detector that only resets on timeout. A restarted AAh must grant a fresh budget. Unrelated stores and reads interleaved within a sequence must not break it, and a protected store must close the window at once rather than wait for expiry. Long random traffic with random tick spacing is compared every cycle against a bench model built from these rules.

// File: rtl/ta_pkg.sv
package ta_pkg;
   typedef enum logic {
      DET_IDLE  = 1'b0,
      DET_ARMED = 1'b1
   } det_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/ta_addr_match.sv
module ta_addr_match #(
   parameter int unsigned AW     = 8,
   parameter int unsigned N_ADDR = 2,
   parameter logic [N_ADDR*AW-1:0] ADDR_LIST = '0
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   logic [N_ADDR-1:0] hit_vec;

   generate
      if (N_ADDR < 1) begin : g_bad_n
         $error("ta_addr_match: N_ADDR must be at least 1");
      end
      for (genvar i = 0; i < N_ADDR; i++) begin : g_cmp
         assign hit_vec[i] = (addr == ADDR_LIST[i*AW +: AW]);
      end
   endgenerate

   assign hit = |hit_vec;
endmodule

// File: rtl/ta_seq_detect.sv
module ta_seq_detect
   import ta_pkg::*;
#(
   parameter int unsigned DW     = 8,
   parameter logic [DW-1:0] KEY1 = 8'hAA,
   parameter logic [DW-1:0] KEY2 = 8'h55,
   parameter int unsigned ARM_MC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          key_wr,
   input  logic [DW-1:0] key_data,
   output logic          armed,
   output logic          open_req
);
   localparam int unsigned CW = cnt_width(ARM_MC);
   localparam logic [CW-1:0] ARM_LOAD = CW'(ARM_MC);
   localparam logic [CW-1:0] ONE      = CW'(1);

   generate
      if (ARM_MC < 1) begin : g_bad_arm
         $error("ta_seq_detect: ARM_MC must be at least 1");
      end
      if (KEY1 == KEY2) begin : g_bad_keys
         $error("ta_seq_detect: the two keys must differ");
      end
   endgenerate

   det_state_e    state_q;
   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DET_IDLE;
         left_q  <= '0;
      end else if (key_wr) begin
         if (key_data == KEY1) begin
            state_q <= DET_ARMED;
            left_q  <= ARM_LOAD;
         end else begin
            state_q <= DET_IDLE;
            left_q  <= '0;
         end
      end else if (state_q == DET_ARMED && tick) begin
         if (left_q == ONE) begin
            state_q <= DET_IDLE;
            left_q  <= '0;
         end else begin
            left_q  <= left_q - ONE;
         end
      end
   end

   assign armed    = (state_q == DET_ARMED);
   assign open_req = key_wr && (key_data == KEY2) && armed;

   // R4: only a first-key store can take the detector out of idle
   p_only_key1_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !(key_wr && key_data == KEY1)) |=> !armed);
endmodule

// File: rtl/ta_window.sv
module ta_window
   import ta_pkg::*;
#(
   parameter int unsigned WIN_MC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   input  logic use_wr,
   output logic permit
);
   generate
      if (WIN_MC < 1) begin : g_bad_win
         $error("ta_window: WIN_MC must be at least 1");
      end else if (WIN_MC == 1) begin : g_flag
         logic open_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              open_q <= 1'b0;
            else if (load)           open_q <= 1'b1;
            else if (use_wr || tick) open_q <= 1'b0;
         end
         assign permit = open_q;
      end else begin : g_count
         localparam int unsigned CW = cnt_width(WIN_MC);
         localparam logic [CW-1:0] WIN_LOAD = CW'(WIN_MC);
         localparam logic [CW-1:0] ONE      = CW'(1);
         logic [CW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 left_q <= '0;
            else if (load)              left_q <= WIN_LOAD;
            else if (left_q != '0) begin
               if (use_wr)              left_q <= '0;
               else if (tick)           left_q <= left_q - ONE;
            end
         end
         assign permit = (left_q != '0);
      end
   endgenerate

   // R5: without a tick or a protected store the open window persists
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (permit && !tick && !use_wr) |=> permit);
endmodule

// File: rtl/timed_access_guard.sv
module timed_access_guard #(
   parameter int unsigned AW       = 8,
   parameter int unsigned DW       = 8,
   parameter logic [AW-1:0] KEY_ADDR = 8'hC7,
   parameter logic [DW-1:0] KEY1   = 8'hAA,
   parameter logic [DW-1:0] KEY2   = 8'h55,
   parameter int unsigned ARM_MC   = 3,
   parameter int unsigned WIN_MC   = 3,
   parameter int unsigned N_PROT   = 2,
   parameter logic [N_PROT*AW-1:0] PROT_ADDRS = 16'hD9D8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mc_tick,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic          permit,
   output logic          rd_sel,
   output logic [DW-1:0] rd_data
);
   generate
      for (genvar i = 0; i < N_PROT; i++) begin : g_chk_list
         if (PROT_ADDRS[i*AW +: AW] == KEY_ADDR) begin : g_clash
            $error("timed_access_guard: key register cannot be protected");
         end
      end
   endgenerate

   logic key_wr;
   logic prot_hit;
   logic prot_wr;
   logic det_armed;
   logic open_req;

   assign key_wr  = wr_en && (wr_addr == KEY_ADDR);
   assign prot_wr = wr_en && prot_hit;

   ta_addr_match #(
      .AW(AW), .N_ADDR(N_PROT), .ADDR_LIST(PROT_ADDRS)
   ) u_match (
      .addr(wr_addr),
      .hit (prot_hit)
   );

   ta_seq_detect #(
      .DW(DW), .KEY1(KEY1), .KEY2(KEY2), .ARM_MC(ARM_MC)
   ) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (mc_tick),
      .key_wr  (key_wr),
      .key_data(wr_data),
      .armed   (det_armed),
      .open_req(open_req)
   );

   ta_window #(
      .WIN_MC(WIN_MC)
   ) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (mc_tick),
      .load  (open_req),
      .use_wr(prot_wr),
      .permit(permit)
   );

   assign rd_sel  = rd_en && (rd_addr == KEY_ADDR);
   assign rd_data = '0;

   // R2: a second key while armed opens the window on the next edge
   p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && wr_data == KEY2 && det_armed) |=> permit);

   // R2: the window only ever rises right after a second-key store
   p_rise_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(permit) |-> $past(key_wr && wr_data == KEY2));

   // R9: a second key with the detector idle keeps a closed window closed
   p_idle_key2_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && wr_data == KEY2 && !det_armed && !permit) |=> !permit);

   // R6: the permitted protected store consumes the window
   p_use_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (permit && prot_wr) |=> !permit);
endmodule

// File: tb/tb_timed_access_guard.sv
module tb_timed_access_guard;
   localparam logic [7:0] KA = 8'hC7;
   localparam logic [7:0] P0 = 8'hD8;
   localparam logic [7:0] P1 = 8'hD9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_addr = '0;
   logic       permit;
   logic       rd_sel;
   logic [7:0] rd_data;

   always #5 clk = ~clk;

   timed_access_guard dut (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .permit(permit), .rd_sel(rd_sel), .rd_data(rd_data)
   );

   int    total = 0;
   int    bad = 0;
   int    cyc = 0;
   int    m_arm = 0;
   int    m_win = 0;
   bit    rnd_tick = 1'b0;
   bit    last_tick = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R1";

   function automatic bit is_prot(input logic [7:0] a);
      return (a == P0) || (a == P1);
   endfunction

   task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, got, exp, cyc);
      end
   endtask

   // called at a negedge; ends at the next negedge
   task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic re, input logic [7:0] ra);
      bit tk;
      bit load;
      tk = rnd_tick ? ($urandom % 3 == 0) : (cyc % 4 == 0);
      chk({7'd0, permit}, {7'd0, m_win > 0}, cur_req);
      mc_tick = tk; wr_en = we; wr_addr = a; wr_data = d; rd_en = re; rd_addr = ra;
      #1;
      if (re) begin
         chk({7'd0, rd_sel}, {7'd0, ra == KA}, "R8");
         if (ra == KA) chk(rd_data, 8'h00, "R8");
      end
      load = we && a == KA && d == 8'h55 && m_arm > 0;
      if (we && a == KA) m_arm = (d == 8'hAA) ? 3 : 0;
      else if (tk && m_arm > 0) m_arm--;
      if (load) m_win = 3;
      else if (m_win > 0) begin
         if (we && is_prot(a)) m_win = 0;
         else if (tk) m_win--;
      end
      last_tick = tk;
      cyc++;
      @(posedge clk);
      @(negedge clk);
      mc_tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic idle();
      step(1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      step(1'b1, a, d, 1'b0, 8'h00);
   endtask

   task automatic idle_ticks(input int n);
      int left = n;
      while (left > 0) begin
         idle();
         if (last_tick) left--;
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      chk({7'd0, permit}, 8'd0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk({7'd0, permit}, 8'd0, "R1");

      // R1 / R9: lone second key after reset
      cur_req = "R9";
      wr(KA, 8'h55); idle();
      chk({7'd0, permit}, 8'd0, "R9");

      // R2 and R5: open, hold two ticks, expire on third
      cur_req = "R2";
      wr(KA, 8'hAA); wr(KA, 8'h55);
      chk({7'd0, permit}, 8'd1, "R2");
      cur_req = "R5";
      idle_ticks(2);
      chk({7'd0, permit}, 8'd1, "R5");
      idle_ticks(1);
      chk({7'd0, permit}, 8'd0, "R5");

      // R3: arming budget boundaries
      cur_req = "R3";
      wr(KA, 8'hAA); idle_ticks(3); wr(KA, 8'h55);
      chk({7'd0, permit}, 8'd0, "R3");
      wr(KA, 8'hAA); idle_ticks(4); wr(KA, 8'h55);
      chk({7'd0, permit}, 8'd0, "R3");
      wr(P0, 8'h03);
      chk({7'd0, permit}, 8'd0, "R6");
      wr(KA, 8'hAA); idle_ticks(2); wr(KA, 8'h55);
      chk({7'd0, permit}, 8'd1, "R3");

      // R6: protected store closes at once
      cur_req = "R6";
      wr(P0, 8'h01);
      chk({7'd0, permit}, 8'd0, "R6");

      // R4: wrong second value, then restart with fresh budget
      cur_req = "R4";
      wr(KA, 8'hAA); wr(KA, 8'h12); wr(KA, 8'h55);
      chk({7'd0, permit}, 8'd0, "R4");
      wr(KA, 8'hAA); idle_ticks(2); wr(KA, 8'hAA); idle_ticks(2); wr(KA, 8'h55);
      chk({7'd0, permit}, 8'd1, "R4");
      wr(P1, 8'h00);
      chk({7'd0, permit}, 8'd0, "R6");

      // R7: unrelated stores and reads inside a sequence and a window
      cur_req = "R7";
      wr(KA, 8'hAA); wr(8'h30, 8'h55);
      step(1'b0, 8'h00, 8'h00, 1'b1, KA);
      wr(KA, 8'h55);
      chk({7'd0, permit}, 8'd1, "R7");
      wr(8'h31, 8'hAA);
      step(1'b0, 8'h00, 8'h00, 1'b1, 8'h44);
      chk({7'd0, permit}, 8'd1, "R7");
      wr(P1, 8'h07);
      chk({7'd0, permit}, 8'd0, "R6");

      // R8: reads
      cur_req = "R8";
      step(1'b0, 8'h00, 8'h00, 1'b1, KA);
      step(1'b0, 8'h00, 8'h00, 1'b1, P0);

      // random traffic with random tick spacing
      cur_req = "R5";
      rnd_tick = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         int r = $urandom % 16;
         if (r < 4)       wr(KA, 8'hAA);
         else if (r < 8)  wr(KA, 8'h55);
         else if (r == 8) wr(KA, 8'($urandom));
         else if (r < 11) wr((r == 9) ? P0 : P1, 8'($urandom));
         else if (r == 11) wr(8'h40, 8'($urandom));
         else if (r == 12) step(1'b0, 8'h00, 8'h00, 1'b1, ($urandom % 2 == 0) ? KA : 8'h10);
         else idle();
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule